// File: doc/BRIEF.md
# PCIe Configuration Access Address Translator

This block turns a configuration request into a memory address inside a window that holds the configuration space of an entire PCIe hierarchy. A request names a bus, an 8-bit device/function number and a 12-bit register offset. The block packs these three fields into a window offset and adds the offset to a 64-bit window base that software programs. Before it issues an address, it checks whether the access may reach the link at all. An access that fails this check is turned into a reject. A rejected read completes with all-ones data, and a rejected write is discarded.

Software sees a small register set. It holds a read-only presence bit, a control word with an enable bit and a last-bus field, the base address split into two 32-bit words, the root bus number, and a read-only word that packs the bus numbers for the root port. A `link_up` input from the link layer decides whether downstream buses can be reached.

Top module: `cfg_ecam_xlate`

## Requirements
- R1: The register at byte offset 0x00 reads 0x00000001 (window present). Writes to it have no effect.
- R2: The control register at offset 0x04 resets to 0x000C0000: the enable bit 0 is clear and the 5-bit last-bus field in bits 20:16 is 12. Both fields read back as written, and all other bits read 0.
- R3: An accepted request produces the address base + ((bus << 20) | (devfn << 12) | reg). The 64-bit base is the low word at offset 0x08 and the high word at offset 0x0C, and a carry from the low word propagates into the high word.
- R4: A request to the root bus with any device/function other than 0 is rejected.
- R5: A request to any bus other than the root bus is rejected while `link_up` is low.
- R6: A request whose bus number is greater than the last-bus field is rejected.
- R7: While the enable bit is clear, every request is rejected.
- R8: A rejected read raises `rsp_valid` with `rsp_data` = 0xFFFFFFFF in the cycle after the request. A rejected write raises only `xl_reject`, with no response.
- R9: An accepted request raises `xl_valid` in the cycle after the request, with `xl_write` copying the request direction. It never raises `xl_reject` or `rsp_valid` in that cycle.
- R10: The read-only word at offset 0x14 holds the root bus in bits 7:0, the root bus + 1 in bits 15:8 and the last-bus field in bits 23:16.
- R11: The root bus number is held in bits 7:0 of the register at offset 0x10 and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link is trained and downstream buses are reachable |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| req_valid | input | 1 | Configuration request present this cycle |
| req_write | input | 1 | Request is a write |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_reg | input | 12 | Target register byte offset |
| xl_valid | output | 1 | Translated address issued |
| xl_write | output | 1 | Direction of the issued or rejected request |
| xl_addr | output | 64 | Translated memory address |
| xl_reject | output | 1 | Request was refused |
| rsp_valid | output | 1 | Local completion for a refused read |
| rsp_data | output | 32 | Completion data for a refused read |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 5-bit last-bus field that resets to 12, and a 64-bit base. With the reset field, buses 13 and above fall outside the range. Widening the field to 31 then puts bus 31 inside and bus 32 just past the edge. A base low word close to its top makes the carry into the high word visible. Moving the root bus to 3 shows that the device/function rule and the link rule both follow the programmed root.

// File: rtl/ecam_pkg.sv
// Shared definitions for the configuration address translator.
// Assumes a 32-bit register data path and byte-addressed registers.
package ecam_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned REG_AW  = 5;

    localparam logic [REG_AW-1:0] OFS_CAP     = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 5'h04;
    localparam logic [REG_AW-1:0] OFS_BASE_LO = 5'h08;
    localparam logic [REG_AW-1:0] OFS_ROOT    = 5'h10;
    localparam logic [REG_AW-1:0] OFS_BUSWORD = 5'h14;

    // Outcome of the access check; anything but VERDICT_PASS is a reject.
    typedef enum logic [2:0] {
        VERDICT_PASS,
        VERDICT_OFF,
        VERDICT_RANGE,
        VERDICT_ROOTFN,
        VERDICT_LINK
    } verdict_t;
endpackage

// File: rtl/ecam_regs.sv
// Software-visible register set: presence, control (enable and last bus),
// window base, root bus, and the packed bus-number word.
// Assumes BUS_W <= 8 so that each bus number fits an 8-bit lane.
module ecam_regs
    import ecam_pkg::*;
#(
    parameter int unsigned BUS_W    = 8,
    parameter int unsigned SIZE_W   = 5,
    parameter int unsigned SIZE_LSB = 16,
    parameter int unsigned SIZE_RST = 12,
    parameter int unsigned BASE_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              enable,
    output logic [BUS_W-1:0]  last_bus,
    output logic [BUS_W-1:0]  root_bus,
    output logic [BASE_W-1:0] base
);
    localparam int unsigned BASE_WORDS = BASE_W / DATA_W;
    localparam int unsigned LANE_W     = 8;

    logic              enable_q;
    logic [SIZE_W-1:0] size_q;
    logic [BUS_W-1:0]  root_q;
    logic [DATA_W-1:0] base_word [BASE_WORDS];

    // Control register: enable bit and last-bus field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            size_q   <= SIZE_W'(SIZE_RST);
        end else if (wr_en && addr == OFS_CTRL) begin
            enable_q <= wdata[0];
            size_q   <= wdata[SIZE_LSB +: SIZE_W];
        end
    end

    // Root bus register.
    always_ff @(posedge clk) begin
        if (!rst_n) root_q <= '0;
        else if (wr_en && addr == OFS_ROOT) root_q <= wdata[BUS_W-1:0];
    end

    // One storage word per 32-bit slice of the window base, low slice first.
    for (genvar w = 0; w < BASE_WORDS; w++) begin : g_base
        localparam logic [REG_AW-1:0] WORD_OFS = OFS_BASE_LO + REG_AW'(4 * w);
        always_ff @(posedge clk) begin
            if (!rst_n) base_word[w] <= '0;
            else if (wr_en && addr == WORD_OFS) base_word[w] <= wdata;
        end
        assign base[w*DATA_W +: DATA_W] = base_word[w];
    end

    assign enable   = enable_q;
    assign root_bus = root_q;
    assign last_bus = {{(BUS_W-SIZE_W){1'b0}}, size_q};

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CAP:  rdata[0] = 1'b1;
            OFS_CTRL: begin
                rdata[0] = enable_q;
                rdata[SIZE_LSB +: SIZE_W] = size_q;
            end
            OFS_ROOT: rdata[BUS_W-1:0] = root_q;
            OFS_BUSWORD: begin
                rdata[0        +: BUS_W] = root_q;
                rdata[LANE_W   +: BUS_W] = root_q + 1'b1;
                rdata[2*LANE_W +: BUS_W] = last_bus;
            end
            default: begin
                for (int w = 0; w < BASE_WORDS; w++)
                    if (addr == OFS_BASE_LO + REG_AW'(4 * w)) rdata = base_word[w];
            end
        endcase
    end

    assert_size_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_CTRL) |=> $stable(size_q) && $stable(enable_q));
    assert_root_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_ROOT) |=> $stable(root_q));
endmodule

// File: rtl/ecam_filter.sv
// Decides whether a configuration request may reach the link.
// Purely combinational; check priority is enable, range, root device, link.
module ecam_filter
    import ecam_pkg::*;
#(
    parameter int unsigned BUS_W   = 8,
    parameter int unsigned DEVFN_W = 8
) (
    input  logic               enable,
    input  logic               link_up,
    input  logic [BUS_W-1:0]   last_bus,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    output verdict_t           verdict
);
    logic on_root;
    assign on_root = (bus == root_bus);

    // Ordered rejection rules.
    always_comb begin
        if (!enable)                       verdict = VERDICT_OFF;
        else if (bus > last_bus)           verdict = VERDICT_RANGE;
        else if (on_root && devfn != '0)   verdict = VERDICT_ROOTFN;
        else if (!on_root && !link_up)     verdict = VERDICT_LINK;
        else                               verdict = VERDICT_PASS;
    end
endmodule

// File: rtl/ecam_issue.sv
// Registers the outcome of a request: a translated address, or a reject
// with an all-ones local completion for reads. Assumes one request per cycle.
module ecam_issue
    import ecam_pkg::*;
#(
    parameter int unsigned BUS_W   = 8,
    parameter int unsigned DEVFN_W = 8,
    parameter int unsigned REG_W   = 12,
    parameter int unsigned BASE_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [REG_W-1:0]   regoff,
    input  verdict_t           verdict,
    input  logic [BASE_W-1:0]  base,
    output logic               xl_valid,
    output logic               xl_write,
    output logic [BASE_W-1:0]  xl_addr,
    output logic               xl_reject,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data
);
    localparam int unsigned OFF_W = BUS_W + DEVFN_W + REG_W;

    logic [OFF_W-1:0]  win_off;
    logic [BASE_W-1:0] target;
    logic              pass;

    assign win_off = {bus, devfn, regoff};
    assign target  = base + BASE_W'(win_off);
    assign pass    = (verdict == VERDICT_PASS);

    // Outcome flags and completion data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid  <= 1'b0;
            xl_write  <= 1'b0;
            xl_reject <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            xl_valid  <= req_valid && pass;
            xl_write  <= req_valid && req_write;
            xl_reject <= req_valid && !pass;
            rsp_valid <= req_valid && !pass && !req_write;
            rsp_data  <= (req_valid && !pass && !req_write) ? '1 : '0;
        end
    end

    // Translated address, captured only for accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) xl_addr <= '0;
        else if (req_valid && pass) xl_addr <= target;
    end

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_valid && xl_reject));
    assert_rsp_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write) && xl_reject && !xl_write);
    assert_rsp_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_data == '1);
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> $stable(xl_addr));
endmodule

// File: rtl/cfg_ecam_xlate.sv
// Top of the configuration access translator: register set, access check
// and registered issue stage. Requests are not back-pressured; each
// request gets its outcome exactly one cycle later.
module cfg_ecam_xlate
    import ecam_pkg::*;
#(
    parameter int unsigned BUS_W    = 8,
    parameter int unsigned DEVFN_W  = 8,
    parameter int unsigned REG_W    = 12,
    parameter int unsigned SIZE_W   = 5,
    parameter int unsigned SIZE_LSB = 16,
    parameter int unsigned SIZE_RST = 12,
    parameter int unsigned BASE_W   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_up,
    input  logic               cfg_wr_en,
    input  logic [4:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [REG_W-1:0]   req_reg,
    output logic               xl_valid,
    output logic               xl_write,
    output logic [BASE_W-1:0]  xl_addr,
    output logic               xl_reject,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data
);
    logic              enable;
    logic [BUS_W-1:0]  last_bus;
    logic [BUS_W-1:0]  root_bus;
    logic [BASE_W-1:0] base;
    verdict_t          verdict;

    ecam_regs #(
        .BUS_W(BUS_W), .SIZE_W(SIZE_W), .SIZE_LSB(SIZE_LSB),
        .SIZE_RST(SIZE_RST), .BASE_W(BASE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .enable(enable),
        .last_bus(last_bus), .root_bus(root_bus), .base(base)
    );

    ecam_filter #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W)) u_filter (
        .enable(enable), .link_up(link_up), .last_bus(last_bus),
        .root_bus(root_bus), .bus(req_bus), .devfn(req_devfn),
        .verdict(verdict)
    );

    ecam_issue #(
        .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .REG_W(REG_W), .BASE_W(BASE_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .bus(req_bus), .devfn(req_devfn),
        .regoff(req_reg), .verdict(verdict), .base(base),
        .xl_valid(xl_valid), .xl_write(xl_write), .xl_addr(xl_addr),
        .xl_reject(xl_reject), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    assert_rootfn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |-> ($past(req_bus) != $past(root_bus) || $past(req_devfn) == '0));
    assert_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && $past(req_bus) != $past(root_bus)) |-> $past(link_up));
    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |-> $past(req_bus) <= $past(last_bus));
    assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |-> $past(enable));
    assert_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> $onehot0({xl_valid, xl_reject}) && (xl_valid || xl_reject));
endmodule

// File: tb/tb_cfg_ecam_xlate.sv
module tb_cfg_ecam_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_reg = '0;
    logic        xl_valid, xl_write, xl_reject, rsp_valid;
    logic [63:0] xl_addr;
    logic [31:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural shadow of the programmed state.
    bit          m_en   = 0;
    int          m_last = 12;
    int          m_root = 0;
    logic [63:0] m_base = '0;

    always #10 clk = ~clk;

    cfg_ecam_xlate dut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .cfg_wr_en(cfg_wr_en),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_reg(req_reg), .xl_valid(xl_valid),
        .xl_write(xl_write), .xl_addr(xl_addr), .xl_reject(xl_reject),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (a)
            5'h04: begin m_en = d[0]; m_last = int'(d[20:16]); end
            5'h08: m_base[31:0]  = d;
            5'h0C: m_base[63:32] = d;
            5'h10: m_root = int'(d[7:0]);
            default: ;
        endcase
    endtask

    task automatic reg_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    // One request; checks its outcome one cycle later and idle the cycle after.
    task automatic access(input int bus, input int devfn, input int rg, input bit wr, input string tag);
        bit ok;
        logic [63:0] exp_addr;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_bus = 8'(bus); req_devfn = 8'(devfn); req_reg = 12'(rg);
        ok = m_en && (bus <= m_last) && !(bus == m_root && devfn != 0)
             && !(bus != m_root && !link_up);
        exp_addr = m_base + 64'((bus << 20) | (devfn << 12) | rg);
        @(negedge clk);
        req_valid = 1'b0;
        chk(xl_valid == ok, {tag, " xl_valid"}, 64'(xl_valid), 64'(ok));
        chk(xl_reject == !ok, {tag, " xl_reject"}, 64'(xl_reject), 64'(!ok));
        chk(xl_write == wr, {tag, " xl_write"}, 64'(xl_write), 64'(wr));
        chk(rsp_valid == (!ok && !wr), {tag, " rsp_valid"}, 64'(rsp_valid), 64'(!ok && !wr));
        if (!ok && !wr) chk(rsp_data == 32'hFFFF_FFFF, {tag, " rsp_data"}, 64'(rsp_data), 64'hFFFF_FFFF);
        if (ok) chk(xl_addr == exp_addr, {tag, " xl_addr"}, xl_addr, exp_addr);
        @(negedge clk);
        chk(!xl_valid && !xl_reject && !rsp_valid, {tag, " idle"},
            64'({xl_valid, xl_reject, rsp_valid}), 64'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xl_valid && !xl_reject && !rsp_valid, "R9 reset outputs",
            64'({xl_valid, xl_reject, rsp_valid}), 64'(0));
        reg_chk(5'h00, 32'h0000_0001, "R1 presence");
        reg_chk(5'h04, 32'h000C_0000, "R2 control reset");
        reg_chk(5'h10, 32'h0000_0000, "R11 root reset");
        reg_chk(5'h14, 32'h000C_0100, "R10 bus word reset");

        access(0, 0, 0, 0, "R7 disabled read");
        access(0, 0, 4, 1, "R7 disabled write");

        reg_wr(5'h04, 32'h000C_0001);
        reg_chk(5'h04, 32'h000C_0001, "R2 control readback");
        reg_wr(5'h08, 32'h1234_0000);
        reg_wr(5'h0C, 32'h0000_0089);
        reg_chk(5'h08, 32'h1234_0000, "R3 base low");
        reg_chk(5'h0C, 32'h0000_0089, "R3 base high");

        access(0, 0, 'h10, 0, "R3 R9 root read");
        access(0, 0, 'h20, 1, "R9 root write");
        access(0, 8, 0, 0, "R4 root devfn");
        access(1, 0, 0, 0, "R5 link down read");
        access(1, 0, 0, 1, "R8 rejected write");
        link_up = 1'b1;
        access(1, 'h0A, 'hFFC, 0, "R3 downstream");
        access(12, 3, 8, 0, "R6 last bus");
        access(13, 0, 0, 0, "R6 past last");

        reg_wr(5'h10, 32'h0000_0003);
        reg_chk(5'h10, 32'h0000_0003, "R11 root readback");
        reg_chk(5'h14, 32'h000C_0403, "R10 bus word");
        access(3, 1, 0, 0, "R4 moved root devfn");
        access(3, 0, 'h40, 0, "R4 moved root pass");
        access(0, 5, 0, 0, "R4 old root no longer root");
        link_up = 1'b0;
        access(0, 0, 0, 0, "R5 link down old root");
        access(3, 0, 0, 0, "R5 root ignores link");
        link_up = 1'b1;

        reg_wr(5'h08, 32'hFFF0_0000);
        access(5, 0, 0, 0, "R3 carry");

        reg_wr(5'h04, 32'h001F_0001);
        reg_chk(5'h04, 32'h001F_0001, "R2 wider size");
        reg_chk(5'h14, 32'h001F_0403, "R10 bus word wider");
        access(31, 'hFF, 'hFFF, 0, "R6 bus 31");
        access(32, 0, 0, 0, "R6 bus 32");

        reg_wr(5'h00, 32'h0000_0000);
        reg_chk(5'h00, 32'h0000_0001, "R1 write ignored");

        reg_wr(5'h04, 32'h001F_0000);
        access(3, 0, 0, 1, "R7 R8 disabled write");
        access(4, 0, 0, 0, "R7 disabled read again");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule